// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Logic

This block is the digital receive side of a 16-bit serial-input converter. A host drives a chip-select, a serial clock and a data line. Words arrive most significant bit first and are shifted into an input shift register. A second register, the converter holding register, drives the code that the analog section converts. Because the two registers are separate, a new value can be preloaded without disturbing the present output.

The host moves the shifted word into the holding register in one of two ways. It can raise chip-select while the load strobe is low, or it can pulse the load strobe low at any later time. An active-low clear input empties both registers on its falling edge and blocks every transfer for as long as it stays low.

All pins are treated as asynchronous. They are brought into a fast system clock through two-flop synchronizers, and edges are found by comparing each synchronized value with its value one cycle earlier. The input shift register has no reset value; only the holding register and the bit counter are reset.

Top module: `dac_serial_front`

## Requirements
- R1: After the synchronous reset `rst`, `dac_code` is 0 (zero scale) and `word_full` is 0.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into bit 0 of the input register and moves the older bits one place toward bit 15. The first bit sent therefore ends up as bit 15 of a 16-bit word.
- R3: When `cs_n` rises while `ldac_n` is low and `clr_n` is high, `dac_code` takes the input register contents.
- R4: When `cs_n` rises while `ldac_n` is high, `dac_code` keeps its old value and the new word waits in the input register.
- R5: A falling edge on `ldac_n` while `clr_n` is high copies the input register into `dac_code`, whatever the level of `cs_n`.
- R6: When a frame has more than 16 rising `sclk` edges, the input register holds the last 16 bits received.
- R7: When a frame has k < 16 rising edges, the input register becomes the previous contents shifted up by k places, with the k new bits in the low positions.
- R8: Toggling `sclk` and `sdi` while `cs_n` is high changes neither register.
- R9: A falling edge on `clr_n` sets both the input register and `dac_code` to 0.
- R10: While `clr_n` is low, `dac_code` does not change: `ldac_n` pulses and chip-select transfers are both ignored. Shifting continues, so a word loaded during the clear can be transferred after `clr_n` returns high.
- R11: `word_full` is 1 once at least 16 rising `sclk` edges have been received in the current frame. It returns to 0 when `cs_n` falls or when a clear occurs. It never gates a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n | input | 1 | Active-low chip select that frames a word |
| sdi | input | 1 | Serial data, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe for the holding register |
| clr_n | input | 1 | Active-low clear; falling edge clears, low level blocks loads |
| dac_code | output | 16 | Holding register driving the converter |
| shift_view | output | 16 | Debug view of the input shift register |
| word_full | output | 1 | At least a full word shifted in the current frame |

## Verification
The hardest condition to reach from the ports is a clear that empties the input register without the holding register ever showing that value directly. The bench reaches it in stages. It first loads a frame while the clear is held low, to show that this frame is shifted in but not transferred. It then releases the clear and strobes the load, so the held word appears at the output. Finally it pulses the clear again and strobes the load, which shows that the input register itself was emptied.

The partial-frame case follows the same indirect path. A short frame is sent, followed by a load strobe, and the output must hold the old word shifted up with the new bits at the bottom.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    // converter resolution
    localparam int DAC_BITS = 16;
    // number of synchronized pins
    localparam int PIN_COUNT = 5;

    // synchronized pin levels, one field per pin
    typedef struct packed {
        logic sclk;
        logic csn;
        logic sdi;
        logic ldacn;
        logic clrn;
    } pin_bus_t;

    // idle level each pin rests at after reset
    localparam pin_bus_t PIN_IDLE = '{
        sclk:  1'b0,
        csn:   1'b1,
        sdi:   1'b0,
        ldacn: 1'b1,
        clrn:  1'b1
    };

    // events and levels seen in the system clock domain
    typedef struct packed {
        logic frame_start;  // chip select fell
        logic frame_end;    // chip select rose
        logic bit_strobe;   // serial clock rose inside a frame
        logic bit_val;      // data level taken with bit_strobe
        logic ldac_fall;    // load strobe fell
        logic clr_fall;     // clear fell
        logic csn_lvl;
        logic ldacn_lvl;
        logic clrn_lvl;
    } evt_t;

    // width of a counter able to hold 0..limit
    function automatic int cnt_width(input int limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int                 WIDTH   = 5,
    parameter logic [WIDTH-1:0]   IDLE    = '0,
    parameter int                 STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= {STAGES{IDLE[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain_q[LAST];
    end

endmodule

// File: rtl/dacfe_events.sv
module dacfe_events
    import dacfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_bus_t pins_now,
    output evt_t     evt
);

    pin_bus_t pins_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_prev_q <= PIN_IDLE;
        end else begin
            pins_prev_q <= pins_now;
        end
    end

    always_comb begin
        evt.frame_start = pins_prev_q.csn  && !pins_now.csn;
        evt.frame_end   = !pins_prev_q.csn && pins_now.csn;
        evt.bit_strobe  = !pins_prev_q.sclk && pins_now.sclk && !pins_now.csn;
        evt.bit_val     = pins_now.sdi;
        evt.ldac_fall   = pins_prev_q.ldacn && !pins_now.ldacn;
        evt.clr_fall    = pins_prev_q.clrn  && !pins_now.clrn;
        evt.csn_lvl     = pins_now.csn;
        evt.ldacn_lvl   = pins_now.ldacn;
        evt.clrn_lvl    = pins_now.clrn;
    end

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
#(
    parameter int WORD_W = DAC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    output logic [WORD_W-1:0] shift_q,
    output logic              word_full
);

    localparam int CNT_W = cnt_width(WORD_W);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    logic [CNT_W-1:0] bit_cnt_q;

    // input register: no reset, its power-up content is undefined
    always_ff @(posedge clk) begin
        if (evt.clr_fall) begin
            shift_q <= '0;
        end else if (evt.bit_strobe) begin
            shift_q <= {shift_q[WORD_W-2:0], evt.bit_val};
        end
    end

    // saturating bit counter, status only
    always_ff @(posedge clk) begin
        if (rst || evt.clr_fall) begin
            bit_cnt_q <= '0;
        end else if (evt.frame_start) begin
            bit_cnt_q <= evt.bit_strobe ? CNT_W'(1) : '0;
        end else if (evt.bit_strobe && bit_cnt_q != CNT_MAX) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    assign word_full = (bit_cnt_q == CNT_MAX);

    // R11: a new frame always starts with the status flag low
    assert_full_clears_on_frame_R11: assert property (
        @(posedge clk) disable iff (rst)
        evt.frame_start |=> !word_full
    );

    // R11: the flag stays set until a frame start or a clear
    assert_full_sticks_R11: assert property (
        @(posedge clk) disable iff (rst)
        (word_full && !evt.frame_start && !evt.clr_fall) |=> word_full
    );

endmodule

// File: rtl/dacfe_holdreg.sv
module dacfe_holdreg
    import dacfe_pkg::*;
#(
    parameter int WORD_W = DAC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  logic [WORD_W-1:0] shift_word,
    output logic [WORD_W-1:0] hold_q
);

    typedef enum logic [1:0] {
        LD_NONE,
        LD_CLEAR,
        LD_COPY
    } load_sel_e;

    load_sel_e load_sel;

    always_comb begin
        load_sel = LD_NONE;
        if (evt.clr_fall) begin
            load_sel = LD_CLEAR;
        end else if (evt.clrn_lvl &&
                     (evt.ldac_fall || (evt.frame_end && !evt.ldacn_lvl))) begin
            load_sel = LD_COPY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            case (load_sel)
                LD_CLEAR: hold_q <= '0;
                LD_COPY:  hold_q <= shift_word;
                default:  hold_q <= hold_q;
            endcase
        end
    end

    // R4: a frame ending with the strobe high leaves the output alone
    assert_no_load_strobe_high_R4: assert property (
        @(posedge clk) disable iff (rst)
        (evt.frame_end && evt.ldacn_lvl && !evt.ldac_fall && !evt.clr_fall)
            |=> $stable(hold_q)
    );

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dacfe_pkg::*;
#(
    parameter int WORD_W = DAC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic [WORD_W-1:0] dac_code,
    output logic [WORD_W-1:0] shift_view,
    output logic              word_full
);

    pin_bus_t pins_raw;
    pin_bus_t pins_sync;
    evt_t     evt;

    assign pins_raw = '{sclk: sclk, csn: cs_n, sdi: sdi, ldacn: ldac_n, clrn: clr_n};

    dacfe_sync #(
        .WIDTH  (PIN_COUNT),
        .IDLE   (PIN_IDLE),
        .STAGES (2)
    ) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pins_raw),
        .sync_out (pins_sync)
    );

    dacfe_events i_events (
        .clk      (clk),
        .rst      (rst),
        .pins_now (pins_sync),
        .evt      (evt)
    );

    dacfe_shifter #(
        .WORD_W (WORD_W)
    ) i_shifter (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .shift_q   (shift_view),
        .word_full (word_full)
    );

    dacfe_holdreg #(
        .WORD_W (WORD_W)
    ) i_holdreg (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .shift_word (shift_view),
        .hold_q     (dac_code)
    );

    // R3: chip select rising with the strobe low transfers the word
    assert_cs_transfer_R3: assert property (
        @(posedge clk) disable iff (rst)
        (evt.frame_end && !evt.ldacn_lvl && evt.clrn_lvl && !evt.clr_fall)
            |=> dac_code == $past(shift_view)
    );

    // R5: a strobe fall copies the input register
    assert_strobe_transfer_R5: assert property (
        @(posedge clk) disable iff (rst)
        (evt.ldac_fall && evt.clrn_lvl)
            |=> dac_code == $past(shift_view)
    );

    // R8: serial activity outside a frame leaves the input register alone
    assert_idle_no_shift_R8: assert property (
        @(posedge clk) disable iff (rst)
        (evt.csn_lvl && !evt.clr_fall) |=> $stable(shift_view)
    );

    // R9: a clear empties both registers
    assert_clear_both_R9: assert property (
        @(posedge clk) disable iff (rst)
        evt.clr_fall |=> (dac_code == '0 && shift_view == '0)
    );

    // R10: the output is frozen while the clear is held
    assert_clear_blocks_R10: assert property (
        @(posedge clk) disable iff (rst)
        (!evt.clrn_lvl && !evt.clr_fall) |=> $stable(dac_code)
    );

endmodule

// File: tb/test_dac_serial_front.sv
module test_dac_serial_front;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int PH         = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdi = 1'b0;
    logic         ldac_n = 1'b1;
    logic         clr_n = 1'b1;
    logic [W-1:0] dac_code;
    logic [W-1:0] shift_view;
    logic         word_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_serial_front i_dac_serial_front (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .ldac_n     (ldac_n),
        .clr_n      (clr_n),
        .dac_code   (dac_code),
        .shift_view (shift_view),
        .word_full  (word_full)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] data, input int n);
        cs_n = 1'b0;
        tick(PH);
        for (int i = n - 1; i >= 0; i--) begin
            sdi  = data[i];
            sclk = 1'b0;
            tick(PH);
            sclk = 1'b1;
            tick(PH);
        end
        sclk = 1'b0;
        tick(PH);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        tick(4);
        ldac_n = 1'b1;
        tick(4);
    endtask

    task automatic t_reset();
        check("R1 dac_code after reset", dac_code, '0);
        check("R1 word_full after reset", {15'd0, word_full}, 16'd0);
    endtask

    task automatic t_cs_transfer();
        ldac_n = 1'b0;
        tick(4);
        send_bits(32'h0000_A5C3, 16);
        check("R3 R2 load on cs rise, msb first", dac_code, 16'hA5C3);
        check("R11 full word flag", {15'd0, word_full}, 16'd1);
        send_bits(32'h0000_FFFF, 16);
        check("R3 full scale", dac_code, 16'hFFFF);
        send_bits(32'h0000_0001, 16);
        check("R3 R2 lsb only", dac_code, 16'h0001);
        send_bits(32'h0000_A5C3, 16);
        ldac_n = 1'b1;
        tick(4);
    endtask

    task automatic t_preload();
        send_bits(32'h0000_1234, 16);
        check("R4 output held with strobe high", dac_code, 16'hA5C3);
        pulse_ldac();
        check("R5 strobe transfers with cs high", dac_code, 16'h1234);
    endtask

    task automatic t_idle_clock();
        for (int i = 0; i < 20; i++) begin
            sdi  = i[0];
            sclk = 1'b1;
            tick(PH);
            sclk = 1'b0;
            tick(PH);
        end
        pulse_ldac();
        check("R8 sclk ignored while cs high", dac_code, 16'h1234);
    endtask

    task automatic t_long_frame();
        send_bits(32'h000A_BCDE, 20);
        check("R11 flag after long frame", {15'd0, word_full}, 16'd1);
        pulse_ldac();
        check("R6 last sixteen bits kept", dac_code, 16'hBCDE);
    endtask

    task automatic t_short_frame();
        send_bits(32'h0000_005A, 8);
        check("R11 flag low after short frame", {15'd0, word_full}, 16'd0);
        check("R7 output held before strobe", dac_code, 16'hBCDE);
        pulse_ldac();
        check("R7 old bits shifted up", dac_code, 16'hDE5A);
    endtask

    task automatic t_clear();
        send_bits(32'h0000_7777, 16);
        check("R4 preload not shown", dac_code, 16'hDE5A);
        clr_n = 1'b0;
        tick(6);
        check("R9 clear zeroes output", dac_code, '0);
        check("R11 flag cleared by clear", {15'd0, word_full}, 16'd0);
        pulse_ldac();
        check("R10 strobe ignored during clear", dac_code, '0);
        ldac_n = 1'b0;
        tick(4);
        send_bits(32'h0000_4321, 16);
        check("R10 cs transfer blocked during clear", dac_code, '0);
        ldac_n = 1'b1;
        tick(4);
        clr_n = 1'b1;
        tick(6);
        check("R10 output still zero after release", dac_code, '0);
        pulse_ldac();
        check("R10 word shifted during clear kept", dac_code, 16'h4321);
        clr_n = 1'b0;
        tick(6);
        clr_n = 1'b1;
        tick(6);
        check("R9 output zero after second clear", dac_code, '0);
        pulse_ldac();
        check("R9 input register was emptied", dac_code, '0);
    endtask

    task automatic t_reset_again();
        send_bits(32'h0000_9999, 16);
        pulse_ldac();
        check("R5 loaded before reset", dac_code, 16'h9999);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(3);
        check("R1 reset returns zero scale", dac_code, '0);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(4);
        t_reset();
        t_cs_transfer();
        t_preload();
        t_idle_clock();
        t_long_frame();
        t_short_frame();
        t_clear();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule